// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Hourly Chime

This block is a 24-hour time-of-day keeper for a display board. It holds seconds, minutes and hours as packed BCD bytes: the tens digit sits in bits 7:4 and the units digit in bits 3:0. All state runs on one system clock. Time moves forward only in cycles where a one-second enable strobe is high. Two held buttons speed up setting: each one forces the carry into its field, so that field gains one step on every second strobe. An active-low clear, which acts asynchronously, returns the whole clock to midnight.

In the last nine seconds of every hour (minute 59, seconds 51 to 59) a chime sequencer drives a beeper and a row of nine lamps. The beeper sounds a half-rate tone on the odd seconds and is silent on the even ones. On the final second it sounds the full-rate tone. One lamp lights per second, moving upward. A scanner steps a digit select through the six time digits, one step per scan strobe, and puts the selected BCD nibble on a shared output for an external segment decoder.

Top module: `bcd_clock_core`

## Requirements
- R1: Seconds count 00..59 in packed BCD (tens in bits 7:4, units in bits 3:0) and return to 00 after 59, one step per cycle with `tick_i` high.
- R2: Hours count 00..23 in packed BCD. The units digit runs 0..9 while tens is 0 or 1, and after 23 the value returns to 00.
- R3: `rst_n_i` low asynchronously clears seconds, minutes, hours, the digit select, the lamps and the speaker to zero.
- R4: In a cycle with `tick_i` low, seconds, minutes and hours hold their values whatever the set buttons, tone or scan inputs do.
- R5: Minutes advance in the same tick that seconds go from 59 to 00, or on any tick while `set_min_i` is high. Either way they gain only one step per tick. When minutes go from 59 to 00, hours advance in that same tick.
- R6: While `set_hour_i` is high, hours advance once per tick. Minutes keep their normal behaviour.
- R7: While minutes read 59 and seconds read 51, 53, 55 or 57, `spk_o` equals an internal divide-by-two of the tone. That divided tone flips on each rising edge of `tone_i` seen at a clock edge, and it starts at 0 after reset. On seconds 52, 54, 56 and 58, `spk_o` is 0. On second 59 it follows `tone_i` directly. At all other times it is 0.
- R8: `lamp_o` has bit (seconds - 51) as its only set bit while minutes read 59 and seconds are 51..59. At all other times it is zero.
- R9: `dig_sel_o` steps 0,1,2,3,4,5,0 on each clock edge with `scan_i` high. `dig_nib_o` shows, for select 0..5: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low clear |
| tick_i | input | 1 | One-second count enable, one cycle wide |
| set_min_i | input | 1 | Minute-set button, debounced and synchronous |
| set_hour_i | input | 1 | Hour-set button, debounced and synchronous |
| tone_i | input | 1 | Tone square wave, sampled on `clk_i` |
| scan_i | input | 1 | Digit scan step strobe |
| sec_o | output | 8 | Seconds, packed BCD |
| min_o | output | 8 | Minutes, packed BCD |
| hour_o | output | 8 | Hours, packed BCD |
| spk_o | output | 1 | Beeper drive |
| lamp_o | output | 9 | One-hot chime lamps |
| dig_sel_o | output | 3 | Current digit select |
| dig_nib_o | output | 4 | BCD nibble of the selected digit |

## Verification
The assertions assume that the set buttons and the tone are already synchronous to `clk_i`. They also assume that `tone_i` changes no faster than once per cycle, so that every rising edge is seen by the divider. The stimulus changes every input only at the falling clock edge and toggles the tone at most once per cycle. It starts each phase from a clean clear or from a state it has reached by normal counting, so the counters never hold values outside BCD range. The carry and range properties then reduce to statements about legal counting.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  typedef logic [7:0] bcd2_t;

  localparam bcd2_t SEC_LAST  = 8'h59;
  localparam bcd2_t MIN_LAST  = 8'h59;
  localparam bcd2_t HOUR_LAST = 8'h23;
  localparam int    LAMP_W    = 9;
  localparam int    DIGITS    = 6;
  localparam int    NIB_W     = 4;

  // Next value of a two-digit BCD field whose final value is last.
  function automatic bcd2_t bcd_next(bcd2_t v, bcd2_t last);
    bcd2_t r;
    if (v == last)
      r = '0;
    else if (v[3:0] == 4'd9)
      r = {v[7:4] + 4'd1, 4'd0};
    else
      r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Lamp pattern for a units digit 1..9 in the chime window.
  function automatic logic [LAMP_W-1:0] chime_lamp(logic [3:0] units);
    logic [LAMP_W-1:0] r;
    r = '0;
    for (int b = 0; b < LAMP_W; b++)
      if (units == 4'(b + 1)) r[b] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr
  import bcd_clock_pkg::*;
#(
  parameter bcd2_t LAST = 8'h59
) (
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  logic  step_i,
  output bcd2_t val_o,
  output logic  wrap_o
);

  bcd2_t val_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)
      val_q <= '0;
    else if (step_i)
      val_q <= bcd_next(val_q, LAST);
  end

  assign val_o  = val_q;
  assign wrap_o = step_i && (val_q == LAST);

endmodule

// File: rtl/chime_seq.sv
module chime_seq
  import bcd_clock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              tone_i,
  input  bcd2_t             sec_i,
  input  bcd2_t             min_i,
  output logic              spk_o,
  output logic [LAMP_W-1:0] lamp_o,
  output logic              window_o
);

  logic tone_q;
  logic tone_half_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tone_q      <= 1'b0;
      tone_half_q <= 1'b0;
    end else begin
      tone_q <= tone_i;
      if (tone_i && !tone_q) tone_half_q <= ~tone_half_q;
    end
  end

  logic [3:0] units;
  assign units    = sec_i[3:0];
  assign window_o = (min_i == MIN_LAST) && (sec_i[7:4] == 4'd5) && (units != 4'd0);

  always_comb begin
    lamp_o = '0;
    spk_o  = 1'b0;
    if (window_o) begin
      lamp_o = chime_lamp(units);
      if (units == 4'd9)
        spk_o = tone_i;
      else if (units[0])
        spk_o = tone_half_q;
    end
  end

endmodule

// File: rtl/digit_scan.sv
module digit_scan
  import bcd_clock_pkg::*;
#(
  parameter int N_DIG = DIGITS,
  parameter int W_NIB = NIB_W
) (
  input  logic                   clk_i,
  input  logic                   rst_n_i,
  input  logic                   step_i,
  input  logic [N_DIG*W_NIB-1:0] fields_i,
  output logic [$clog2(N_DIG)-1:0] sel_o,
  output logic [W_NIB-1:0]       nib_o
);

  localparam int SEL_W = $clog2(N_DIG);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(N_DIG - 1);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)
      sel_q <= '0;
    else if (step_i)
      sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
  end

  logic [N_DIG-1:0][W_NIB-1:0] nibs;
  for (genvar d = 0; d < N_DIG; d++) begin : g_nib
    assign nibs[d] = fields_i[d*W_NIB +: W_NIB];
  end

  always_comb begin
    nib_o = '0;
    for (int d = 0; d < N_DIG; d++)
      if (sel_q == SEL_W'(d)) nib_o = nibs[d];
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        tick_i,
  input  logic        set_min_i,
  input  logic        set_hour_i,
  input  logic        tone_i,
  input  logic        scan_i,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic        spk_o,
  output logic [8:0]  lamp_o,
  output logic [2:0]  dig_sel_o,
  output logic [3:0]  dig_nib_o
);

  // Named internal events, observed by the bound checker.
  logic sec_wrap, min_step, min_wrap, hour_step, hour_wrap, chime_win;

  bcd_field_ctr #(.LAST(SEC_LAST)) u_sec (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .step_i(tick_i),
    .val_o(sec_o), .wrap_o(sec_wrap)
  );

  assign min_step = tick_i && (sec_wrap || set_min_i);

  bcd_field_ctr #(.LAST(MIN_LAST)) u_min (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .step_i(min_step),
    .val_o(min_o), .wrap_o(min_wrap)
  );

  assign hour_step = tick_i && (min_wrap || set_hour_i);

  bcd_field_ctr #(.LAST(HOUR_LAST)) u_hour (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .step_i(hour_step),
    .val_o(hour_o), .wrap_o(hour_wrap)
  );

  chime_seq u_chime (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .tone_i(tone_i),
    .sec_i(sec_o), .min_i(min_o),
    .spk_o(spk_o), .lamp_o(lamp_o), .window_o(chime_win)
  );

  digit_scan #(.N_DIG(DIGITS), .W_NIB(NIB_W)) u_scan (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .step_i(scan_i),
    .fields_i({hour_o, min_o, sec_o}),
    .sel_o(dig_sel_o), .nib_o(dig_nib_o)
  );

endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       tick_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic       spk_o,
  input logic [8:0] lamp_o,
  input logic [2:0] dig_sel_o,
  input logic       sec_wrap,
  input logic       min_wrap,
  input logic       hour_wrap,
  input logic       chime_win
);

  a_r1_sec_legal: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sec_o[7:4] <= 4'd5) && (sec_o[3:0] <= 4'd9));

  a_r2_hour_legal: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (hour_o <= 8'h23) && (hour_o[3:0] <= 4'd9));

  a_r2_hour_wrap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hour_wrap |=> (hour_o == 8'h00));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !tick_i |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)));

  a_r5_sec_carry: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sec_wrap |=> (min_o != $past(min_o)));

  a_r5_min_carry: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    min_wrap |=> (hour_o != $past(hour_o)));

  a_r8_lamp_onehot: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(lamp_o) && (chime_win == ($countones(lamp_o) == 1)));

  a_r7_spk_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !chime_win |-> !spk_o);

  a_r9_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    dig_sel_o <= 3'd5);

endmodule

bind bcd_clock_core bcd_clock_chk u_chk (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .spk_o(spk_o), .lamp_o(lamp_o), .dig_sel_o(dig_sel_o),
  .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
  .chime_win(chime_win)
);

// File: tb/bcd_clock_core_bench.sv
module bcd_clock_core_bench;

  logic clk = 1'b0;
  logic rst_n, tick, set_min, set_hour, tone, scan;
  logic [7:0] sec_o, min_o, hour_o;
  logic spk_o;
  logic [8:0] lamp_o;
  logic [2:0] dig_sel_o;
  logic [3:0] dig_nib_o;

  always #5 clk = ~clk;

  bcd_clock_core u_bcd_clock_core (
    .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .set_min_i(set_min),
    .set_hour_i(set_hour), .tone_i(tone), .scan_i(scan),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .spk_o(spk_o),
    .lamp_o(lamp_o), .dig_sel_o(dig_sel_o), .dig_nib_o(dig_nib_o)
  );

  int checks = 0, fails = 0;
  int s = 0, m = 0, h = 0, sel = 0;
  logic half = 1'b0, prev_tone = 1'b0;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (model %0d:%0d:%0d)", req, act, exp, h, m, s);
    end
  endtask

  task automatic verify();
    logic [8:0] e_lamp;
    logic e_spk;
    int nib;
    e_lamp = '0;
    e_spk  = 1'b0;
    if (m == 59 && s >= 51) begin
      e_lamp = 9'(1 << (s - 51));
      if (s == 59) e_spk = tone;
      else if (s % 2 == 1) e_spk = half;
    end
    case (sel)
      0: nib = s % 10;  1: nib = s / 10;
      2: nib = m % 10;  3: nib = m / 10;
      4: nib = h % 10;  default: nib = h / 10;
    endcase
    chk("R1 sec", 32'(sec_o), 32'(bcd(s)));
    chk("R5 min", 32'(min_o), 32'(bcd(m)));
    chk("R2/R6 hour", 32'(hour_o), 32'(bcd(h)));
    chk("R8 lamp", 32'(lamp_o), 32'(e_lamp));
    chk("R7 spk", 32'(spk_o), 32'(e_spk));
    chk("R9 sel", 32'(dig_sel_o), 32'(sel));
    chk("R9 nib", 32'(dig_nib_o), 32'(nib));
  endtask

  // Drive one cycle after a falling edge, update the model, check at the next falling edge.
  task automatic cyc(input logic t, input logic sm, input logic sh, input logic sc, input logic tn);
    logic minc, hinc;
    tick = t; set_min = sm; set_hour = sh; scan = sc; tone = tn;
    if (t) begin
      minc = sm || (s == 59);
      hinc = sh || (minc && m == 59);
      s = (s + 1) % 60;
      if (minc) m = (m + 1) % 60;
      if (hinc) h = (h + 1) % 24;
    end
    if (sc) sel = (sel == 5) ? 0 : sel + 1;
    if (tn && !prev_tone) half = ~half;
    prev_tone = tn;
    @(negedge clk);
    verify();
  endtask

  task automatic model_clear();
    s = 0; m = 0; h = 0; sel = 0; half = 1'b0; prev_tone = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 0; set_min = 0; set_hour = 0; tone = 0; scan = 0;
    repeat (3) @(negedge clk);
    // R3: clear state
    chk("R3 sec", 32'(sec_o), 0);
    chk("R3 min", 32'(min_o), 0);
    chk("R3 hour", 32'(hour_o), 0);
    chk("R3 sel", 32'(dig_sel_o), 0);
    chk("R3 lamp", 32'(lamp_o), 0);
    chk("R3 spk", 32'(spk_o), 0);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);

    // R1 R2 R5 R7 R8 R9: full day plus wrap past midnight, tick every cycle
    for (int i = 0; i < 86410; i++)
      cyc(1'b1, 1'b0, 1'b0, (i % 3) != 0, 1'(i & 1));

    // R4: tick low, other inputs busy, time must hold
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'(i & 1));
      chk("R4 hold", 32'({hour_o, min_o, sec_o}), 32'({bcd(h), bcd(m), bcd(s)}));
    end

    // R5: minute set held through two minute wraps
    for (int i = 0; i < 130; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

    // R6: hour set held past the 23 -> 00 wrap
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    // R7 R8: bring minutes to 58, then run slowly through the chime window
    while (m != 58) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4 * 140; i++)
      cyc((i % 4) == 3, 1'b0, 1'b0, (i % 5) == 0, 1'(i & 1));

    // R3: asynchronous clear mid-run
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    chk("R3 async time", 32'({hour_o, min_o, sec_o}), 0);
    chk("R3 async sel", 32'(dig_sel_o), 0);
    chk("R3 async lamp/spk", 32'({lamp_o, spk_o}), 0);
    tick = 0; scan = 0; tone = 0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);

    finish_run();
  end

endmodule